// File: doc/BRIEF.md
# Bus Address Alignment Guard

The guard sits on the slave side of an AHB-Lite address phase and feeds a single-entry request register that hands addresses to an AXI4 address channel. Every accepted address phase is checked against its transfer size. This covers the first beat of a burst and every following beat. Byte transfers always pass. A halfword needs a clear bit 0. A word needs clear bits [1:0]. Sizes wider than the 32-bit data bus are illegal.

A run-time policy input picks what happens to a misaligned halfword or word. In correcting mode, the low address bits are cleared and the request is forwarded. In rejecting mode, no request is made and the master receives the two-cycle AHB ERROR response. An oversized transfer cannot be repaired, so it is rejected in both modes. This means the downstream side only ever receives addresses aligned to their size.

Every violation is logged in three places: a sticky flag, a saturating counter and a copy of the offending address as the master presented it. A synchronous clear input resets all three.

Top module: `addr_align_guard`

## Requirements
- R1: A byte transfer (size code 000) at any address is forwarded unchanged and is never counted as a violation.
- R2: A halfword (size 001) is aligned only when address bit 0 is 0, and a word (size 010) only when address bits [1:0] are 00. Aligned transfers are forwarded unchanged. Size codes 011 and above are violations that are rejected in both policy modes.
- R3: An address phase is accepted only when select, ready and transfer type are all valid: select and ready must both be high, and the transfer type must be NONSEQ (10) or SEQ (11). IDLE (00) and BUSY (01) phases, and phases with select or ready low, make no request, give no error response and leave the log unchanged.
- R4: With mode_reject = 0, a misaligned halfword or word is forwarded with its low address bits cleared. req_valid rises in the cycle after the accepting edge, and hresp stays low.
- R5: With mode_reject = 1, a misaligned transfer produces no request. In the first cycle after the accepting edge, hresp = 1 and hreadyout = 0. In the second cycle, hresp = 1 and hreadyout = 1. After that, hresp returns to 0.
- R6: SEQ beats inside a burst are checked and handled exactly like the NONSEQ beat that starts the burst.
- R7: While req_valid = 1 and req_ready = 0, hreadyout is 0 and the request fields are held stable. The request retires on the first edge at which req_ready = 1.
- R8: viol_sticky is set by any violation in either mode and remains set until cleared.
- R9: viol_count counts one per violation and saturates at 16'hFFFF.
- R10: viol_addr holds the address of the most recent violation as presented, before any correction.
- R11: clr_log = 1 at an edge sets viol_sticky, viol_count and viol_addr to zero. The clear wins over a violation accepted at the same edge.
- R12: The policy is sampled at the accepting edge. A change of mode_reject after that edge does not alter how the transfer already accepted is handled.
- R13: The forwarded request carries the transfer's size code and write direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_reject | input | 1 | Policy: 0 corrects, 1 rejects |
| clr_log | input | 1 | Synchronous clear of the violation log |
| hsel | input | 1 | Slave select |
| haddr | input | 32 | Address-phase address |
| htrans | input | 2 | Transfer type (IDLE 00, BUSY 01, NONSEQ 10, SEQ 11) |
| hsize | input | 3 | Transfer size code |
| hwrite | input | 1 | Write direction |
| hready | input | 1 | Bus ready seen by all slaves |
| hreadyout | output | 1 | This slave's ready |
| hresp | output | 1 | Error response |
| req_valid | output | 1 | Forwarded request valid |
| req_ready | input | 1 | Downstream accepts the request |
| req_addr | output | 32 | Forwarded, aligned address |
| req_size | output | 3 | Forwarded size code |
| req_write | output | 1 | Forwarded direction |
| viol_sticky | output | 1 | Sticky violation flag |
| viol_count | output | 16 | Saturating violation count |
| viol_addr | output | 32 | Last offending address |

## Verification
Every result is due one edge after the address phase that causes it: the forwarded request, the first error cycle and all three log outputs. The second error cycle follows one edge later, and the idle response one edge after that. Inputs change on the falling clock edge. Each check samples on the falling edge that follows the rising edge at which the result should appear. As a result, a result that comes a cycle early or a cycle late is seen as a mismatch. The hreadyout stall is combinational from req_ready, so the bench also checks it within the same cycle, shortly after req_ready changes.

// File: rtl/aag_pkg.sv
`timescale 1ns/1ps
package aag_pkg;
  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_BUSY   = 2'b01;
  localparam logic [1:0] TR_NONSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ    = 2'b11;

  typedef enum logic [1:0] {
    RSP_OKAY = 2'd0,
    RSP_ERR1 = 2'd1,
    RSP_ERR2 = 2'd2
  } rsp_st_e;

  typedef struct packed {
    logic       accept;
    logic       forward;
    logic       reject;
    logic       violation;
  } decide_t;
endpackage

// File: rtl/aag_align_chk.sv
`timescale 1ns/1ps
module aag_align_chk #(
  parameter int AW     = 32,
  parameter int DATA_W = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [2:0]    size,
  output logic          aligned,
  output logic          oversize,
  output logic [AW-1:0] fixed_addr
);
  localparam int          BUS_BYTES = DATA_W / 8;
  localparam logic [2:0]  MAX_SIZE  = 3'($clog2(BUS_BYTES));

  logic [AW-1:0] low_mask;

  always_comb begin
    low_mask   = ~({AW{1'b1}} << size);
    oversize   = (size > MAX_SIZE);
    aligned    = ((addr & low_mask) == '0);
    fixed_addr = addr & ~low_mask;
  end
endmodule

// File: rtl/aag_viol_log.sv
`timescale 1ns/1ps
module aag_viol_log #(
  parameter int AW    = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             hit,
  input  logic [AW-1:0]    hit_addr,
  output logic             sticky,
  output logic [CNT_W-1:0] count,
  output logic [AW-1:0]    last_addr
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sticky    <= 1'b0;
      count     <= '0;
      last_addr <= '0;
    end else if (hit) begin
      sticky    <= 1'b1;
      last_addr <= hit_addr;
      if (count != CNT_MAX) count <= count + 1'b1;
    end
  end

  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sticky && !clr) |=> sticky);

  // R9
  cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (count == CNT_MAX && !clr) |=> (count == CNT_MAX));

  // R11
  clr_log_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0 && !sticky && last_addr == '0));
endmodule

// File: rtl/aag_req_reg.sv
`timescale 1ns/1ps
module aag_req_reg #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] in_addr,
  input  logic [2:0]    in_size,
  input  logic          in_write,
  input  logic          ready,
  output logic          valid,
  output logic [AW-1:0] out_addr,
  output logic [2:0]    out_size,
  output logic          out_write,
  output logic          stall
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid     <= 1'b0;
      out_addr  <= '0;
      out_size  <= '0;
      out_write <= 1'b0;
    end else if (load) begin
      valid     <= 1'b1;
      out_addr  <= in_addr;
      out_size  <= in_size;
      out_write <= in_write;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end

  assign stall = valid && !ready;

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> (valid && $stable(out_addr) && $stable(out_size)));

  // R4
  req_half_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && out_size == 3'd1) |-> (out_addr[0] == 1'b0));

  // R4
  req_word_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && out_size == 3'd2) |-> (out_addr[1:0] == 2'b00));

  // R2
  req_size_chk: assert property (@(posedge clk) disable iff (rst)
    valid |-> (out_size <= 3'd2));
endmodule

// File: rtl/addr_align_guard.sv
`timescale 1ns/1ps
module addr_align_guard #(
  parameter int AW     = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_reject,
  input  logic             clr_log,
  input  logic             hsel,
  input  logic [AW-1:0]    haddr,
  input  logic [1:0]       htrans,
  input  logic [2:0]       hsize,
  input  logic             hwrite,
  input  logic             hready,
  output logic             hreadyout,
  output logic             hresp,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [AW-1:0]    req_addr,
  output logic [2:0]       req_size,
  output logic             req_write,
  output logic             viol_sticky,
  output logic [CNT_W-1:0] viol_count,
  output logic [AW-1:0]    viol_addr
);
  import aag_pkg::*;

  logic          is_aligned;
  logic          is_oversize;
  logic [AW-1:0] aligned_addr;
  logic [AW-1:0] fwd_addr;
  logic          stall;
  decide_t       dec;
  rsp_st_e       rsp_q, rsp_d;

  aag_align_chk #(.AW(AW), .DATA_W(DATA_W)) chk_i (
    .addr       (haddr),
    .size       (hsize),
    .aligned    (is_aligned),
    .oversize   (is_oversize),
    .fixed_addr (aligned_addr)
  );

  always_comb begin
    dec.accept    = hsel && hready && (htrans == TR_NONSEQ || htrans == TR_SEQ);
    dec.violation = dec.accept && (is_oversize || !is_aligned);
    dec.forward   = dec.accept && !is_oversize && (is_aligned || !mode_reject);
    dec.reject    = dec.accept && !dec.forward;
    fwd_addr      = is_aligned ? haddr : aligned_addr;
  end

  aag_req_reg #(.AW(AW)) req_i (
    .clk       (clk),
    .rst       (rst),
    .load      (dec.forward),
    .in_addr   (fwd_addr),
    .in_size   (hsize),
    .in_write  (hwrite),
    .ready     (req_ready),
    .valid     (req_valid),
    .out_addr  (req_addr),
    .out_size  (req_size),
    .out_write (req_write),
    .stall     (stall)
  );

  aag_viol_log #(.AW(AW), .CNT_W(CNT_W)) log_i (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr_log),
    .hit       (dec.violation),
    .hit_addr  (haddr),
    .sticky    (viol_sticky),
    .count     (viol_count),
    .last_addr (viol_addr)
  );

  always_comb begin
    rsp_d = rsp_q;
    case (rsp_q)
      RSP_OKAY: if (dec.reject) rsp_d = RSP_ERR1;
      RSP_ERR1: rsp_d = RSP_ERR2;
      RSP_ERR2: rsp_d = dec.reject ? RSP_ERR1 : RSP_OKAY;
      default:  rsp_d = RSP_OKAY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rsp_q <= RSP_OKAY;
    else     rsp_q <= rsp_d;
  end

  assign hresp     = (rsp_q != RSP_OKAY);
  assign hreadyout = (rsp_q != RSP_ERR1) && !stall;

  // R5
  err_two_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (hresp && !hreadyout) |=> (hresp && hreadyout));

  // R5
  err_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    (hresp && !hreadyout) |-> !req_valid);

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!hsel || !hready || !htrans[1]) |=> $stable(viol_count) || $past(clr_log));
endmodule

// File: tb/addr_align_guard_tb_top.sv
`timescale 1ns/1ps
module addr_align_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        mode_reject, clr_log, hsel, hwrite, req_ready;
  logic [31:0] haddr;
  logic [1:0]  htrans;
  logic [2:0]  hsize;
  logic        hreadyout, hresp, req_valid, req_write, viol_sticky;
  logic [31:0] req_addr, viol_addr;
  logic [2:0]  req_size;
  logic [15:0] viol_count;
  wire         hready = hreadyout;
  int          total = 0;
  int          bad   = 0;

  always #2 clk = ~clk;

  addr_align_guard dut_i (
    .clk(clk), .rst(rst), .mode_reject(mode_reject), .clr_log(clr_log),
    .hsel(hsel), .haddr(haddr), .htrans(htrans), .hsize(hsize),
    .hwrite(hwrite), .hready(hready), .hreadyout(hreadyout), .hresp(hresp),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .viol_sticky(viol_sticky),
    .viol_count(viol_count), .viol_addr(viol_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic [1:0] tr, input logic [2:0] sz, input logic [31:0] a, input logic w);
    htrans = tr; hsize = sz; haddr = a; hwrite = w;
  endtask

  task automatic one(input logic [1:0] tr, input logic [2:0] sz, input logic [31:0] a, input logic w);
    drive(tr, sz, a, w);
    step();
    htrans = 2'b00;
  endtask

  task automatic t_reset();
    chk("R7 reset req_valid", {31'b0, req_valid}, 32'd0);
    chk("R5 reset hresp", {31'b0, hresp}, 32'd0);
    chk("R7 reset hreadyout", {31'b0, hreadyout}, 32'd1);
    chk("R8 reset sticky", {31'b0, viol_sticky}, 32'd0);
    chk("R9 reset count", {16'b0, viol_count}, 32'd0);
  endtask

  task automatic t_byte();
    mode_reject = 1'b0; req_ready = 1'b1;
    one(2'b10, 3'd0, 32'h0000_1003, 1'b1);
    chk("R1 byte valid", {31'b0, req_valid}, 32'd1);
    chk("R1 byte addr", req_addr, 32'h0000_1003);
    chk("R13 size", {29'b0, req_size}, 32'd0);
    chk("R13 write", {31'b0, req_write}, 32'd1);
    chk("R1 no violation", {31'b0, viol_sticky}, 32'd0);
    step();
    chk("R7 retired", {31'b0, req_valid}, 32'd0);
  endtask

  task automatic t_aligned();
    one(2'b10, 3'd1, 32'h0000_2002, 1'b0);
    chk("R2 half addr", req_addr, 32'h0000_2002);
    chk("R13 read", {31'b0, req_write}, 32'd0);
    one(2'b10, 3'd2, 32'h0000_3004, 1'b0);
    chk("R2 word addr", req_addr, 32'h0000_3004);
    chk("R2 word size", {29'b0, req_size}, 32'd2);
    chk("R2 no count", {16'b0, viol_count}, 32'd0);
    step();
  endtask

  task automatic t_correct();
    mode_reject = 1'b0;
    one(2'b10, 3'd2, 32'h0000_4006, 1'b1);
    chk("R4 word fixed", req_addr, 32'h0000_4004);
    chk("R4 valid", {31'b0, req_valid}, 32'd1);
    chk("R4 hresp low", {31'b0, hresp}, 32'd0);
    chk("R8 sticky", {31'b0, viol_sticky}, 32'd1);
    chk("R9 count 1", {16'b0, viol_count}, 32'd1);
    chk("R10 last addr", viol_addr, 32'h0000_4006);
    one(2'b10, 3'd1, 32'h0000_5001, 1'b0);
    chk("R4 half fixed", req_addr, 32'h0000_5000);
    chk("R9 count 2", {16'b0, viol_count}, 32'd2);
    step();
  endtask

  task automatic t_reject();
    mode_reject = 1'b1;
    one(2'b10, 3'd2, 32'h0000_6002, 1'b1);
    chk("R5 err1 no req", {31'b0, req_valid}, 32'd0);
    chk("R5 err1 hresp", {31'b0, hresp}, 32'd1);
    chk("R5 err1 hreadyout", {31'b0, hreadyout}, 32'd0);
    chk("R10 reject addr", viol_addr, 32'h0000_6002);
    step();
    chk("R5 err2 hresp", {31'b0, hresp}, 32'd1);
    chk("R5 err2 hreadyout", {31'b0, hreadyout}, 32'd1);
    chk("R5 err2 no req", {31'b0, req_valid}, 32'd0);
    step();
    chk("R5 okay after", {31'b0, hresp}, 32'd0);
    chk("R9 count 3", {16'b0, viol_count}, 32'd3);
  endtask

  task automatic t_oversize();
    mode_reject = 1'b0;
    one(2'b10, 3'd3, 32'h0000_7000, 1'b0);
    chk("R2 oversize no req", {31'b0, req_valid}, 32'd0);
    chk("R2 oversize hresp", {31'b0, hresp}, 32'd1);
    step(); step();
    chk("R2 oversize count", {16'b0, viol_count}, 32'd4);
  endtask

  task automatic t_ignore();
    mode_reject = 1'b0;
    one(2'b01, 3'd2, 32'h0000_8103, 1'b0);
    chk("R3 busy no req", {31'b0, req_valid}, 32'd0);
    one(2'b00, 3'd2, 32'h0000_8203, 1'b0);
    chk("R3 idle no req", {31'b0, req_valid}, 32'd0);
    hsel = 1'b0;
    one(2'b10, 3'd2, 32'h0000_8303, 1'b0);
    hsel = 1'b1;
    chk("R3 unselected no req", {31'b0, req_valid}, 32'd0);
    chk("R3 count unchanged", {16'b0, viol_count}, 32'd4);
    chk("R3 addr unchanged", viol_addr, 32'h0000_7000);
    chk("R3 hresp low", {31'b0, hresp}, 32'd0);
  endtask

  task automatic t_burst();
    mode_reject = 1'b0; req_ready = 1'b1;
    drive(2'b10, 3'd2, 32'h0000_9000, 1'b1);
    step();
    chk("R6 beat0", req_addr, 32'h0000_9000);
    drive(2'b11, 3'd2, 32'h0000_9006, 1'b1);
    step();
    chk("R6 seq fixed", req_addr, 32'h0000_9004);
    chk("R6 seq counted", {16'b0, viol_count}, 32'd5);
    drive(2'b11, 3'd2, 32'h0000_9008, 1'b1);
    step();
    htrans = 2'b00;
    chk("R6 beat2", req_addr, 32'h0000_9008);
    chk("R6 beat2 valid", {31'b0, req_valid}, 32'd1);
    step();
  endtask

  task automatic t_stall();
    req_ready = 1'b0;
    one(2'b10, 3'd2, 32'h0000_A000, 1'b0);
    chk("R7 stall hreadyout", {31'b0, hreadyout}, 32'd0);
    step(); step();
    chk("R7 still valid", {31'b0, req_valid}, 32'd1);
    chk("R7 addr held", req_addr, 32'h0000_A000);
    chk("R7 still stalled", {31'b0, hreadyout}, 32'd0);
    req_ready = 1'b1;
    #1;
    chk("R7 ready releases", {31'b0, hreadyout}, 32'd1);
    step();
    chk("R7 retired", {31'b0, req_valid}, 32'd0);
  endtask

  task automatic t_mode_switch();
    mode_reject = 1'b0;
    one(2'b10, 3'd2, 32'h0000_B001, 1'b0);
    mode_reject = 1'b1;
    chk("R12 forwarded", {31'b0, req_valid}, 32'd1);
    chk("R12 fixed addr", req_addr, 32'h0000_B000);
    chk("R12 no error", {31'b0, hresp}, 32'd0);
    step();
    one(2'b10, 3'd2, 32'h0000_B002, 1'b0);
    mode_reject = 1'b0;
    chk("R12 rejected", {31'b0, hresp}, 32'd1);
    step();
    chk("R12 no request", {31'b0, req_valid}, 32'd0);
    step();
  endtask

  task automatic t_clear();
    clr_log = 1'b1;
    step();
    clr_log = 1'b0;
    chk("R11 count", {16'b0, viol_count}, 32'd0);
    chk("R11 sticky", {31'b0, viol_sticky}, 32'd0);
    chk("R11 addr", viol_addr, 32'd0);
    mode_reject = 1'b0;
    drive(2'b10, 3'd2, 32'h0000_C003, 1'b0);
    clr_log = 1'b1;
    step();
    clr_log = 1'b0; htrans = 2'b00;
    chk("R11 clear wins", {16'b0, viol_count}, 32'd0);
    chk("R11 clear wins sticky", {31'b0, viol_sticky}, 32'd0);
    step();
  endtask

  task automatic t_saturate();
    mode_reject = 1'b0; req_ready = 1'b1;
    drive(2'b10, 3'd1, 32'h0000_0001, 1'b0);
    repeat (65534) @(posedge clk);
    @(negedge clk);
    chk("R9 count FFFE", {16'b0, viol_count}, 32'h0000_FFFE);
    repeat (6) @(posedge clk);
    @(negedge clk);
    htrans = 2'b00;
    chk("R9 saturated", {16'b0, viol_count}, 32'h0000_FFFF);
    step();
    chk("R9 still saturated", {16'b0, viol_count}, 32'h0000_FFFF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; mode_reject = 1'b0; clr_log = 1'b0; hsel = 1'b1;
    hwrite = 1'b0; req_ready = 1'b1; haddr = '0; htrans = 2'b00; hsize = 3'd0;
    repeat (3) step();
    rst = 1'b0;
    step();
    t_reset();
    t_byte();
    t_aligned();
    t_correct();
    t_reject();
    t_oversize();
    t_ignore();
    t_burst();
    t_stall();
    t_mode_switch();
    t_clear();
    t_saturate();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule